// File: doc/BRIEF.md
# Reset-Addressed Field Delay Memory

This block is a serial field memory with two clock domains, used as a programmable digital delay line. It has no full or empty flags. The write side and the read side each have an enable and an address-zeroing strobe, so the delay is simply how many read-side edges separate the two strobes. A word written at some edge comes out of the read side exactly that many edges later. Storage is split into identical 8-bit planes that share both clocks, so two planes form one 16-bit word. The write and read clocks are independent and may run at different rates. Either clock may be held still for any length of time, and stored words and address state are kept.

Each plane keeps a small head buffer that mirrors the lowest locations of the array. After a read strobe, the first words come from this buffer with the same single-edge timing as every later word. A free-running timer in the read domain raises refresh requests. An arbiter lets a request run only on a read edge that carries no transfer. A request that has to wait is held until it can run, so refresh never shows at the ports.

Top module: `field_delay_mem`

## Requirements
- R1: While `rst` is high on a read-clock edge, `rd_data` becomes zero, and both address counters return to location 0.
- R2: `wr_data` is stored as independent 8-bit lanes. Bits [7:0] go to plane 0 and bits [15:8] go to plane 1, and each lane comes back in the same bit positions of `rd_data`.
- R3: `wr_zero` high on a write-clock edge sets the write address to 0. It overrides `wr_en`, so no word is stored on that edge.
- R4: `rd_zero` high on a read-clock edge sets the read address to 0. It overrides `rd_en`, so no read happens on that edge and `rd_data` keeps its value.
- R5: On a read-clock edge with `rd_en` high and `rd_zero` low, `rd_data` takes the word at the current read address, and the address then advances by one. With both enables held high and the read strobe given N edges after the write strobe, `rd_data` after each read edge is the word written N edges earlier.
- R6: With its enable low and its strobe low, a port keeps its address. The write side stores nothing, and the read side keeps `rd_data` unchanged.
- R7: An address counter at location DEPTH-1 goes to location 0 on its next advance, so the memory behaves as a circular buffer.
- R8: A read and a write to the same location on the same edge return the word stored there before that edge.
- R9: Locations below HEAD are read from the head buffer. They give the same data with the same single-edge timing as the main array, including the first word after a read strobe.
- R10: A refresh request is raised every REF_PERIOD read-clock edges. It runs only on an edge where `rd_en` is low, stays pending until then, and never changes stored data or read timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr | input | 1 | Write-side clock |
| clk_rd | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_en | input | 1 | Store `wr_data` and advance the write address |
| wr_zero | input | 1 | Return the write address to 0 |
| wr_data | input | 16 | Word to store (two 8-bit planes) |
| rd_en | input | 1 | Read a word and advance the read address |
| rd_zero | input | 1 | Return the read address to 0 |
| rd_data | output | 16 | Registered read word |

## Verification
Every read result is due one read-clock edge after the edge that carries `rd_en`, because the only register on the path is the output register. The bench drives inputs on the falling edge and, for each read it issues, queues the word predicted by its own model of addresses and memory. It then checks `rd_data` shortly after the next rising edge. On edges without a read, the same sampling point checks that `rd_data` still holds its last value, so strobes, disabled cycles and refresh deferrals are all checked at the edge where they would show. Refresh and head-buffer use cannot be seen from the ports. They are covered by runs where reads continue through many refresh periods and cross the head-buffer boundary.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  localparam int unsigned LANE_W = 8;

  function automatic int unsigned ptr_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/fdm_addr_ctr.sv
module fdm_addr_ctr #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zero,
  input  logic          en,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || zero) begin
      addr <= '0;
    end else if (en) begin
      addr <= (addr == LAST) ? '0 : addr + 1'b1;
    end
  end
endmodule

// File: rtl/fdm_plane.sv
module fdm_plane #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned HEAD  = 256,
  parameter int unsigned AW    = 10,
  parameter int unsigned PW    = 8
) (
  input  logic          clk_wr,
  input  logic          wr_go,
  input  logic [AW-1:0] waddr,
  input  logic [PW-1:0] wdata,
  input  logic          clk_rd,
  input  logic          rst,
  input  logic          rd_go,
  input  logic [AW-1:0] raddr,
  output logic [PW-1:0] rdata
);
  localparam int unsigned HAW = fdm_pkg::ptr_bits(HEAD);

  logic [PW-1:0] main_mem [DEPTH];
  logic [PW-1:0] head_mem [HEAD];

  logic w_in_head;
  logic r_in_head;
  assign w_in_head = (int'(waddr) < int'(HEAD));
  assign r_in_head = (int'(raddr) < int'(HEAD));

  always_ff @(posedge clk_wr) begin
    if (wr_go) begin
      main_mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk_wr) begin
    if (wr_go && w_in_head) begin
      head_mem[waddr[HAW-1:0]] <= wdata;
    end
  end

  always_ff @(posedge clk_rd) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_go) begin
      rdata <= r_in_head ? head_mem[raddr[HAW-1:0]] : main_mem[raddr];
    end
  end
endmodule

// File: rtl/fdm_refresh.sv
module fdm_refresh #(
  parameter int unsigned PERIOD = 64,
  parameter int unsigned ROWS   = 512,
  parameter int unsigned RW     = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  output logic          pend,
  output logic [RW-1:0] row
);
  localparam int unsigned TW = fdm_pkg::ptr_bits(PERIOD);
  localparam logic [TW-1:0] T_LAST = TW'(PERIOD - 1);
  localparam logic [RW-1:0] R_LAST = RW'(ROWS - 1);

  logic [TW-1:0] timer;
  logic          tick;
  logic          run;

  assign tick = (timer == T_LAST);
  assign run  = pend && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      timer <= '0;
    end else begin
      timer <= tick ? '0 : timer + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      row  <= '0;
    end else begin
      pend <= tick || (pend && !run);
      if (run) begin
        row <= (row == R_LAST) ? '0 : row + 1'b1;
      end
    end
  end
endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem #(
  parameter int unsigned DEPTH      = 1024,
  parameter int unsigned HEAD       = 256,
  parameter int unsigned PLANES     = 2,
  parameter int unsigned REF_PERIOD = 64,
  parameter int unsigned REF_ROWS   = 512,
  localparam int unsigned DW        = PLANES * fdm_pkg::LANE_W
) (
  input  logic          clk_wr,
  input  logic          clk_rd,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_zero,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_zero,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned AW = fdm_pkg::ptr_bits(DEPTH);
  localparam int unsigned RW = fdm_pkg::ptr_bits(REF_ROWS);
  localparam int unsigned PW = fdm_pkg::LANE_W;

  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic          wr_go;
  logic          rd_go;
  logic          ref_pend;
  logic [RW-1:0] ref_row;

  assign wr_go = wr_en && !wr_zero && !rst;
  assign rd_go = rd_en && !rd_zero && !rst;

  fdm_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_wctr (
    .clk(clk_wr), .rst(rst), .zero(wr_zero), .en(wr_en), .addr(waddr)
  );

  fdm_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_rctr (
    .clk(clk_rd), .rst(rst), .zero(rd_zero), .en(rd_en), .addr(raddr)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    fdm_plane #(.DEPTH(DEPTH), .HEAD(HEAD), .AW(AW), .PW(PW)) u_plane (
      .clk_wr(clk_wr),
      .wr_go (wr_go),
      .waddr (waddr),
      .wdata (wr_data[p*PW +: PW]),
      .clk_rd(clk_rd),
      .rst   (rst),
      .rd_go (rd_go),
      .raddr (raddr),
      .rdata (rd_data[p*PW +: PW])
    );
  end

  fdm_refresh #(.PERIOD(REF_PERIOD), .ROWS(REF_ROWS), .RW(RW)) u_ref (
    .clk(clk_rd), .rst(rst), .busy(rd_en), .pend(ref_pend), .row(ref_row)
  );
endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 16,
  parameter int unsigned RW    = 9
) (
  input logic          clk_wr,
  input logic          clk_rd,
  input logic          rst,
  input logic          wr_en,
  input logic          wr_zero,
  input logic          rd_en,
  input logic          rd_zero,
  input logic [AW-1:0] waddr,
  input logic [AW-1:0] raddr,
  input logic [DW-1:0] rd_data,
  input logic          ref_pend,
  input logic [RW-1:0] ref_row
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  AST_RST_CLEAR: assert property (@(posedge clk_rd)
    rst |=> (rd_data == '0 && raddr == '0)); // R1

  AST_WR_ZERO: assert property (@(posedge clk_wr) disable iff (rst)
    wr_zero |=> (waddr == '0)); // R3

  AST_RD_ZERO: assert property (@(posedge clk_rd) disable iff (rst)
    rd_zero |=> (raddr == '0 && $stable(rd_data))); // R4

  AST_RD_STEP: assert property (@(posedge clk_rd) disable iff (rst)
    (rd_en && !rd_zero && raddr != LAST) |=> (raddr == AW'($past(raddr) + 1'b1))); // R5

  AST_RD_WRAP: assert property (@(posedge clk_rd) disable iff (rst)
    (rd_en && !rd_zero && raddr == LAST) |=> (raddr == '0)); // R7

  AST_WR_WRAP: assert property (@(posedge clk_wr) disable iff (rst)
    (wr_en && !wr_zero && waddr == LAST) |=> (waddr == '0)); // R7

  AST_RD_HOLD: assert property (@(posedge clk_rd) disable iff (rst)
    (!rd_en && !rd_zero) |=> ($stable(raddr) && $stable(rd_data))); // R6

  AST_WR_HOLD: assert property (@(posedge clk_wr) disable iff (rst)
    (!wr_en && !wr_zero) |=> $stable(waddr)); // R6

  AST_REF_DEFER: assert property (@(posedge clk_rd) disable iff (rst)
    (ref_pend && rd_en) |=> ref_pend); // R10

  AST_REF_SLOT: assert property (@(posedge clk_rd) disable iff (rst)
    (ref_row != $past(ref_row)) |-> (!$past(rd_en) && $past(ref_pend))); // R10
endmodule

bind field_delay_mem fdm_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .RW(RW)) u_chk (
  .clk_wr  (clk_wr),
  .clk_rd  (clk_rd),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_zero (wr_zero),
  .rd_en   (rd_en),
  .rd_zero (rd_zero),
  .waddr   (waddr),
  .raddr   (raddr),
  .rd_data (rd_data),
  .ref_pend(ref_pend),
  .ref_row (ref_row)
);

// File: tb/field_delay_mem_bench.sv
module field_delay_mem_bench;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned HEAD  = 16;
  localparam int unsigned DW    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, wr_zero = 1'b0, rd_en = 1'b0, rd_zero = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  int unsigned cycles = 0;

  logic [DW-1:0] model [DEPTH];
  int unsigned   wp = 0, rp = 0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic [DW-1:0] last_out = '0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  field_delay_mem #(
    .DEPTH(DEPTH), .HEAD(HEAD), .PLANES(2), .REF_PERIOD(12), .REF_ROWS(8)
  ) u_field_delay_mem (
    .clk_wr(clk), .clk_rd(clk), .rst(rst),
    .wr_en(wr_en), .wr_zero(wr_zero), .wr_data(wr_data),
    .rd_en(rd_en), .rd_zero(rd_zero), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(input int unsigned k, input int unsigned seed);
    return {8'((k * 7 + seed) & 8'hff), 8'((255 - k * 3 + seed * 5) & 8'hff)};
  endfunction

  // Driver: one edge of stimulus; predicts the read result from the requirements.
  task automatic step(input logic we, input logic wz, input logic [DW-1:0] wd,
                      input logic re, input logic rz, input string tag);
    @(negedge clk);
    wr_en = we; wr_zero = wz; wr_data = wd; rd_en = re; rd_zero = rz;
    if (re && !rz) begin
      exp_q.push_back(model[rp]);   // old contents on same-address collision (R8)
      tag_q.push_back(tag);
    end
    if (rz) rp = 0;
    else if (re) rp = (rp == DEPTH - 1) ? 0 : rp + 1;   // wrap (R7)
    if (wz) wp = 0;                                     // strobe wins over enable (R3)
    else if (we) begin
      model[wp] = wd;
      wp = (wp == DEPTH - 1) ? 0 : wp + 1;
    end
  endtask

  // Monitor: compares one edge after each read, else checks that the output holds.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        checks++;
        if (exp_q.size() > 0) begin
          logic [DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rd_data !== e) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
          end
          last_out = e;
        end else if (rd_data !== last_out) begin
          fails++;
          $display("FAIL R6/R4: rd_data=%h expected held %h", rd_data, last_out);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        fails++;
        $display("FAIL watchdog: cycles=%0d expected < 200000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (rd_data !== '0) begin
      fails++;
      $display("FAIL R1: rd_data=%h expected 0000", rd_data);
    end
    rst = 1'b0;

    // Fill one lap with distinct per-lane values (R2); reads idle, output holds (R6).
    step(1'b0, 1'b1, '0, 1'b0, 1'b0, "R3");
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, pat(i, 1), 1'b0, 1'b0, "R2");

    // Both strobes together, then same-address read/write each edge: old lap first (R8),
    // crossing the head-buffer boundary (R9) and wrapping (R7).
    step(1'b0, 1'b1, '0, 1'b0, 1'b1, "R4");
    for (int i = 0; i < 2 * DEPTH; i++) step(1'b1, 1'b0, pat(i, 9), 1'b1, 1'b0, "R8");

    // Delay line of N=5: write strobe with enable high stores nothing (R3),
    // read strobe with enable high reads nothing (R4).
    step(1'b1, 1'b1, 16'hdead, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, pat(i, 33), 1'b0, 1'b0, "R5");
    step(1'b1, 1'b0, pat(4, 33), 1'b1, 1'b1, "R4");
    for (int i = 5; i < 5 + 3 * DEPTH; i++) step(1'b1, 1'b0, pat(i, 33), 1'b1, 1'b0, "R5");

    // Reads paused while writes continue, then both ports stalled (R6).
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, pat(i, 77), 1'b0, 1'b0, "R6");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 16'hffff, 1'b0, 1'b0, "R6");

    // Long continuous reads across many refresh periods, with short gaps (R10).
    for (int i = 0; i < 4 * DEPTH; i++)
      step(1'b1, 1'b0, pat(i, 51), (i % 29) != 0, 1'b0, "R10");

    // Fresh read strobe: first words from head buffer with no extra delay (R9).
    step(1'b0, 1'b0, '0, 1'b0, 1'b1, "R4");
    for (int i = 0; i < HEAD + 4; i++) step(1'b0, 1'b0, '0, 1'b1, 1'b0, "R9");

    step(1'b0, 1'b0, '0, 1'b0, 1'b0, "R6");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule